// File: doc/BRIEF.md
# Sticky-Input GPIO Bank With Blink

This block manages a bank of general-purpose pins. Each position is fixed at build time as output-only, bidirectional or absent. A use-select register decides, pin by pin, whether the pad is driven by the block's own level register or by an alternate-function path from elsewhere in the chip. After reset every implemented pin belongs to the alternate path. Selected outputs can blink from a divided slow tick. One output is open-drain.

Bidirectional pins are watched by a qualifier. Once a pin has been seen high on two sample strobes in a row, the pin's status bit latches. The bit then stays set until software clears it by writing a one to it. Two sample strobes come in from outside: a fast bus-rate enable and a slow real-time enable. A sleep input picks which of them counts. Masked status bits are ORed into a single pending output.

Software reaches the registers through a request/response port. A request is taken on any cycle where `req_valid` and `req_ready` are both high. A read returns its data one cycle later on `rsp_data`, with `rsp_valid` high. The response holds steady until `rsp_ready` is high. While a response is waiting, `req_ready` stays low, so further requests are held off.

Top module: `gpio_bank`

## Requirements
- R1: Out of reset, the use-select register is zero. Every implemented pin shows `alt_out`/`alt_oe` on `pad_out`/`pad_oe`. The level register holds one at the high-reset position (bit 20) and zero everywhere else.
- R2: When a pin's use-select bit is 1, an output-only or bidirectional push-pull pin drives its level bit on `pad_out` with `pad_oe` high. Writes to use-select keep only implemented positions.
- R3: A bidirectional pin's status bit sets on a selected sample strobe that finds the pin high when the previous selected strobe also found it high. A single isolated high sample leaves the bit clear. A set bit stays set after the pin falls.
- R4: With `sleep` low, only `fast_tick` counts as a sample strobe. With `sleep` high, only `slow_tick` counts.
- R5: Writing ones to the status register (address 3) clears those bits. Reading the level register returns the status bit at bidirectional positions and the level bit at output-only positions.
- R6: When the blink bit of the blinking pin (bit 25) is set, that pin's driven value inverts every `BLINK_HALF` slow ticks. Clearing the blink bit returns the pin to its level bit on the next cycle. Blink bits at other positions read as zero.
- R7: The open-drain pin (bit 22), in GPIO mode, never drives high. It has `pad_oe` low when its level bit is 1 and drives low with `pad_oe` high when its level bit is 0.
- R8: Absent positions (26, 29, 30, 31) read as zero in every register, ignore writes and never assert `pad_oe`.
- R9: `sts_pending` is high exactly when some status bit is set whose mask bit (address 4, bidirectional positions only) is also set.
- R10: Register map: 0 use-select, 1 level, 2 blink, 3 status, 4 mask. Any other address reads zero. A pending response holds `rsp_valid` and `rsp_data` steady and keeps `req_ready` low until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | 1 selects the slow sample strobe |
| fast_tick | input | 1 | Bus-rate sample enable |
| slow_tick | input | 1 | Real-time sample enable, also the blink time base |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Read data |
| alt_out | input | 32 | Alternate-function output values |
| alt_oe | input | 32 | Alternate-function output enables |
| pad_in | input | 32 | Pad input levels, already synchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| sts_pending | output | 1 | OR of masked status bits |

## Verification
The bench builds the block with the default pin map and sets `BLINK_HALF` to 4 in place of the one-second default of 16384 slow ticks. With that value, two full blink half-periods, and the return to the level value, fit into a few dozen cycles. Keeping the default pin map means the open-drain, high-reset, blinking and absent positions are all exercised at their real bit positions.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    ADDR_USE    = 3'd0,
    ADDR_LEVEL  = 3'd1,
    ADDR_BLINK  = 3'd2,
    ADDR_STATUS = 3'd3,
    ADDR_MASK   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_bank_sticky.sv
module gpio_bank_sticky #(
  parameter int N = 32,
  parameter logic [N-1:0] SENSE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         samp_en,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    if (SENSE_MASK[i]) begin : g_sense
      logic hist_q;
      logic sts_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_q <= 1'b0;
          sts_q  <= 1'b0;
        end else begin
          if (samp_en) hist_q <= pin_in[i];
          // a qualifying sample wins over a same-cycle clear
          if (samp_en && pin_in[i] && hist_q) sts_q <= 1'b1;
          else if (clr[i])                    sts_q <= 1'b0;
        end
      end
      assign sts[i] = sts_q;
    end else begin : g_none
      assign sts[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_bank_blink.sv
module gpio_bank_blink #(
  parameter int HALF = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic phase
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        phase <= ~phase;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_bank_pad.sv
module gpio_bank_pad #(
  parameter int N = 32,
  parameter logic [N-1:0] IMPL_MASK = '1,
  parameter logic [N-1:0] OD_MASK   = '0
) (
  input  logic [N-1:0] use_gpio,
  input  logic [N-1:0] gpio_val,
  input  logic [N-1:0] alt_out,
  input  logic [N-1:0] alt_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);
  for (genvar i = 0; i < N; i++) begin : g_pad
    if (!IMPL_MASK[i]) begin : g_absent
      assign pad_out[i] = 1'b0;
      assign pad_oe[i]  = 1'b0;
    end else if (OD_MASK[i]) begin : g_od
      assign pad_out[i] = use_gpio[i] ? 1'b0 : alt_out[i];
      assign pad_oe[i]  = use_gpio[i] ? ~gpio_val[i] : alt_oe[i];
    end else begin : g_pp
      assign pad_out[i] = use_gpio[i] ? gpio_val[i] : alt_out[i];
      assign pad_oe[i]  = use_gpio[i] ? 1'b1 : alt_oe[i];
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter logic [N_PINS-1:0] OUT_ONLY_MASK   = 32'h00FF_0000,
  parameter logic [N_PINS-1:0] BIDIR_MASK      = 32'h1B00_FFFF,
  parameter logic [N_PINS-1:0] OD_MASK         = 32'h0040_0000,
  parameter logic [N_PINS-1:0] RESET_HIGH_MASK = 32'h0010_0000,
  parameter logic [N_PINS-1:0] BLINK_MASK      = 32'h0200_0000,
  parameter int BLINK_HALF = 16384,
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [N_PINS-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [N_PINS-1:0] rsp_data,
  input  logic [N_PINS-1:0] alt_out,
  input  logic [N_PINS-1:0] alt_oe,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic              sts_pending
);
  localparam logic [N_PINS-1:0] IMPL_MASK = OUT_ONLY_MASK | BIDIR_MASK;

  logic [N_PINS-1:0] use_q, lvl_q, blink_q, mask_q;
  logic [N_PINS-1:0] sts_q, sts_clr, gpio_val, rd_val;
  logic              samp_en, blink_phase, take, wr;
  reg_addr_e         addr;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign wr        = take && req_write;
  assign addr      = reg_addr_e'(req_addr);
  assign samp_en   = sleep ? slow_tick : fast_tick;
  assign sts_clr   = (wr && addr == ADDR_STATUS) ? req_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q   <= '0;
      lvl_q   <= RESET_HIGH_MASK & IMPL_MASK;
      blink_q <= '0;
      mask_q  <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_USE:   use_q   <= req_wdata & IMPL_MASK;
        ADDR_LEVEL: lvl_q   <= req_wdata & IMPL_MASK;
        ADDR_BLINK: blink_q <= req_wdata & BLINK_MASK;
        ADDR_MASK:  mask_q  <= req_wdata & BIDIR_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_USE:    rd_val = use_q;
      ADDR_LEVEL:  rd_val = (lvl_q & OUT_ONLY_MASK) | sts_q;
      ADDR_BLINK:  rd_val = blink_q;
      ADDR_STATUS: rd_val = sts_q;
      ADDR_MASK:   rd_val = mask_q;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  gpio_bank_sticky #(.N(N_PINS), .SENSE_MASK(BIDIR_MASK)) u_sticky (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .pin_in(pad_in),
    .clr(sts_clr), .sts(sts_q)
  );

  gpio_bank_blink #(.HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .phase(blink_phase)
  );

  assign gpio_val = (lvl_q & ~blink_q) | ({N_PINS{blink_phase}} & blink_q);

  gpio_bank_pad #(.N(N_PINS), .IMPL_MASK(IMPL_MASK), .OD_MASK(OD_MASK)) u_pad (
    .use_gpio(use_q), .gpio_val(gpio_val), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign sts_pending = |(sts_q & mask_q);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int N = 32,
  parameter logic [N-1:0] IMPL = '1,
  parameter logic [N-1:0] OD = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pad_out,
  input logic [N-1:0] pad_oe,
  input logic [N-1:0] pad_in,
  input logic [N-1:0] use_q,
  input logic [N-1:0] sts_q,
  input logic [N-1:0] sts_clr,
  input logic         samp_en,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [N-1:0] rsp_data
);
  p_absent_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~IMPL) == '0);

  p_od_never_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & pad_oe & OD & use_q) == '0);

  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sts_q) & ~$past(sts_clr)) & ~sts_q) == '0));

  p_set_needs_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(pad_in)) == '0));

  p_set_needs_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((sts_q & ~$past(sts_q)) == '0) || $past(samp_en)));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind gpio_bank gpio_bank_chk #(
  .N(N_PINS), .IMPL(OUT_ONLY_MASK | BIDIR_MASK), .OD(OD_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in),
  .use_q(use_q), .sts_q(sts_q), .sts_clr(sts_clr), .samp_en(samp_en),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam int N = 32;
  localparam int HALF = 4;
  localparam logic [N-1:0] OUTM  = 32'h00FF_0000;
  localparam logic [N-1:0] BIDM  = 32'h1B00_FFFF;
  localparam logic [N-1:0] IMPLM = OUTM | BIDM;
  localparam logic [N-1:0] ODM   = 32'h0040_0000;

  logic clk = 0, rst_n = 0, sleep = 0, fast_tick = 0, slow_tick = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [2:0] req_addr = 0;
  logic [N-1:0] req_wdata = 0, alt_out = 32'hA5C3_5A3C, alt_oe = 32'hFFFF_FFFF, pad_in = 0;
  logic req_ready, rsp_valid, sts_pending;
  logic [N-1:0] rsp_data, pad_out, pad_oe;

  int n_chk = 0, n_bad = 0;
  logic [N-1:0] m_use = 0, m_lvl = 0, rd;

  always #10 clk = ~clk;

  gpio_bank #(.BLINK_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .alt_out(alt_out), .alt_oe(alt_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .sts_pending(sts_pending)
  );

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rdreg(logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    d = rsp_data;
  endtask

  task automatic ticks(bit fast, bit slow, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); fast_tick = fast; slow_tick = slow;
      @(negedge clk); fast_tick = 0; slow_tick = 0;
    end
  endtask

  function automatic logic [N-1:0] exp_out();
    logic [N-1:0] g = m_lvl & ~ODM;
    return ((m_use & g) | (~m_use & alt_out)) & IMPLM;
  endfunction
  function automatic logic [N-1:0] exp_oe();
    logic [N-1:0] g = ~(ODM & m_lvl);
    return ((m_use & g) | (~m_use & alt_oe)) & IMPLM;
  endfunction

  task automatic t_reset();
    check("R1 pad_out alt", pad_out, alt_out & IMPLM);
    check("R1 pad_oe alt", pad_oe, alt_oe & IMPLM);
    rdreg(3'd0, rd); check("R1 use zero", rd, '0);
    rdreg(3'd1, rd); check("R1 level reset", rd, 32'h0010_0000);
    m_lvl = 32'h0010_0000;
  endtask

  task automatic t_level();
    wr(3'd0, '1); m_use = IMPLM;
    rdreg(3'd0, rd); check("R2 use write masked", rd, IMPLM);
    wr(3'd1, 32'h0093_00F0); m_lvl = 32'h0093_00F0;
    @(negedge clk);
    check("R2 pad_out level", pad_out, exp_out());
    check("R2 pad_oe level", pad_oe, exp_oe());
  endtask

  task automatic t_od();
    wr(3'd1, 32'h0040_0000); m_lvl = 32'h0040_0000;
    @(negedge clk);
    check("R7 od released oe", {31'd0, pad_oe[22]}, 32'd0);
    check("R7 od out low", {31'd0, pad_out[22]}, 32'd0);
    wr(3'd1, 32'h0000_0000); m_lvl = 0;
    @(negedge clk);
    check("R7 od drive low", {30'd0, pad_oe[22], pad_out[22]}, 32'd2);
  endtask

  task automatic t_absent();
    wr(3'd1, '1); m_lvl = IMPLM;
    rdreg(3'd1, rd); check("R8 level absent zero", rd, OUTM);
    check("R8 absent oe", pad_oe & ~IMPLM, '0);
    wr(3'd2, '1);
    rdreg(3'd2, rd); check("R6 blink only bit 25", rd, 32'h0200_0000);
    wr(3'd2, '0);
    wr(3'd4, '1);
    rdreg(3'd4, rd); check("R8 mask absent zero", rd, BIDM);
    wr(3'd4, '0);
    rdreg(3'd7, rd); check("R10 unmapped reads zero", rd, '0);
  endtask

  task automatic t_sticky();
    sleep = 0;
    pad_in = 32'h8; ticks(1, 0, 1);
    pad_in = 0;     ticks(1, 0, 1);
    rdreg(3'd3, rd); check("R3 single sample no set", rd, '0);
    pad_in = 32'h8; ticks(1, 0, 2);
    pad_in = 0;     ticks(1, 0, 2);
    rdreg(3'd3, rd); check("R3 sticky set and held", rd, 32'h8);
    rdreg(3'd1, rd); check("R5 level reads status", rd & BIDM, 32'h8);
    wr(3'd3, 32'h8);
    rdreg(3'd3, rd); check("R5 w1c clears", rd, '0);
  endtask

  task automatic t_sleep();
    sleep = 1; pad_in = 32'h0100_0000;
    ticks(1, 0, 3);
    rdreg(3'd3, rd); check("R4 fast ignored asleep", rd, '0);
    ticks(0, 1, 2);
    rdreg(3'd3, rd); check("R4 slow samples asleep", rd, 32'h0100_0000);
    pad_in = 0; sleep = 0;
    wr(3'd3, '1);
  endtask

  task automatic t_pending();
    pad_in = 32'h20; ticks(1, 0, 2); pad_in = 0;
    @(negedge clk);
    check("R9 pending masked off", {31'd0, sts_pending}, 32'd0);
    wr(3'd4, 32'h20);
    @(negedge clk);
    check("R9 pending on", {31'd0, sts_pending}, 32'd1);
    wr(3'd3, 32'h20);
    @(negedge clk);
    check("R9 pending after clear", {31'd0, sts_pending}, 32'd0);
    wr(3'd4, 0);
  endtask

  task automatic t_blink();
    logic v;
    wr(3'd1, 32'h0); m_lvl = 0;
    wr(3'd2, 32'h0200_0000);
    @(negedge clk); v = pad_out[25];
    ticks(0, 1, HALF);
    check("R6 blink toggled", {31'd0, pad_out[25]}, {31'd0, ~v});
    ticks(0, 1, HALF);
    check("R6 blink toggled back", {31'd0, pad_out[25]}, {31'd0, v});
    wr(3'd1, 32'h0200_0000);
    wr(3'd2, 0);
    check("R6 blink off level", {31'd0, pad_out[25]}, 32'd1);
  endtask

  task automatic t_backpressure();
    logic [N-1:0] first;
    wr(3'd4, 32'h0000_0300);
    rsp_ready = 0;
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = 3'd4;
    @(posedge clk); @(negedge clk); req_valid = 0;
    first = rsp_data;
    check("R10 read data", first, 32'h0000_0300);
    @(negedge clk);
    check("R10 held valid/ready", {30'd0, rsp_valid, req_ready}, 32'd2);
    check("R10 held data", rsp_data, first);
    rsp_ready = 1;
    @(negedge clk);
    check("R10 released", {30'd0, rsp_valid, req_ready}, 32'd1);
    wr(3'd4, 0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_level();
    t_od();
    t_absent();
    t_sticky();
    t_sleep();
    t_pending();
    t_blink();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule